// File: doc/BRIEF.md
# Subscriber Line Control and Loopback Router

This block holds the 8-bit control byte of one subscriber line. It routes three channels between the line side and the system side: two 8-bit bearer channels (B1, B2) and one 2-bit signalling channel (D). One control bit activates the line. Four bits pick loopback paths. Two active-low bits gate the D channel in each direction. One bit enables the line's interrupt, and the block exposes that bit as an output.

The control byte is written through a single-cycle write port and can be read back at all times, whether the line is active or not. The six routed channel outputs are registered, and they update only on clock edges where the frame strobe is high. A control change therefore appears at the next frame boundary, and every channel changes in the same frame. Outputs that carry no data hold the idle value, which is all ones.

Top module: `line_ctrl_router`

## Requirements
- R1: After reset the control byte reads 0, `irq_en_o` is 0 and all six channel outputs are all ones.
- R2: A write with `wr_en_i` high stores `wr_data_i`, and the value appears on `ctrl_o` one cycle later. This holds whether the line is active or deactivated.
- R3: Bit 7 is the activation bit (1 = active). While it is 0, every channel output takes the all-ones value at each frame update, whatever the other bits hold. Loopback bits therefore have no effect on a deactivated line.
- R4: On an active line with bits 6..3 clear, the line outputs carry the system inputs and the system outputs carry the line inputs, channel for channel.
- R5: Bit 5 selects the full line loopback. Line receive B1, B2 and D return to the line outputs, and the system outputs still carry the line receive data.
- R6: Bit 4 selects the B1-only line loopback. Line B1 returns to the line, while line B2 and D come from the system inputs.
- R7: Bit 3 selects the B2-only line loopback. Line B2 returns to the line, while line B1 and D come from the system inputs.
- R8: When bit 5 is set, it overrides bits 4 and 3.
- R9: Bit 6 selects the full digital loopback. The system inputs return to the system outputs. When no line loopback is selected, the line outputs still carry the system inputs.
- R10: `irq_en_o` follows bit 2 of the stored control byte.
- R11: Bit 1 = 1 disables D toward the line. The line D output then idles at 2'b11 whenever its source would be the system side.
- R12: Bit 0 = 1 disables D toward the system. The system D output then idles at 2'b11.
- R13: Channel outputs change only on a clock edge where `frame_i` is high. At that edge they take the inputs and control value present before the edge, so a write in the same cycle applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| ctrl_o | output | 8 | Stored control byte |
| irq_en_o | output | 1 | Interrupt enable for this line |
| frame_i | input | 1 | Frame strobe; routed outputs update on it |
| line_rx_b1_i | input | 8 | B1 received from line |
| line_rx_b2_i | input | 8 | B2 received from line |
| line_rx_d_i | input | 2 | D received from line |
| sys_tx_b1_i | input | 8 | B1 from system side |
| sys_tx_b2_i | input | 8 | B2 from system side |
| sys_tx_d_i | input | 2 | D from system side |
| line_tx_b1_o | output | 8 | B1 toward line |
| line_tx_b2_o | output | 8 | B2 toward line |
| line_tx_d_o | output | 2 | D toward line |
| sys_rx_b1_o | output | 8 | B1 toward system |
| sys_rx_b2_o | output | 8 | B2 toward system |
| sys_rx_d_o | output | 2 | D toward system |

## Verification
Faults in this block show up at the ports within one frame. A wrong bit in the stored byte is visible on `ctrl_o` and `irq_en_o` one cycle after the write. A wrong channel select corrupts the matching output on the first frame edge after the control change. A register that loads outside the frame strobe shows up one cycle early, because the inputs move every cycle. The bench changes all data inputs every cycle, so a path taken from the wrong source cannot match the expected value by accident. It compares every output against a behavioural model on every clock.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned NUM_CH = 3; // 0:B1 1:B2 2:D

  typedef struct packed {
    logic active;
    logic dig_lb;
    logic line_lb;
    logic b1_lb;
    logic b2_lb;
    logic irq_en;
    logic dtx_dis;
    logic drx_dis;
  } ctrl_t;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_LINE = 2'd2
  } src_e;
endpackage

// File: rtl/lcr_ctrl_reg.sv
module lcr_ctrl_reg
  import lcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_o <= '0;
    else if (wr_en_i) ctrl_o <= ctrl_t'(wr_data_i);
  end
endmodule

// File: rtl/lcr_sel_decode.sv
module lcr_sel_decode
  import lcr_pkg::*;
(
  input  ctrl_t ctrl_i,
  output src_e  tx_sel_o [NUM_CH],
  output src_e  rx_sel_o [NUM_CH]
);
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      tx_sel_o[c] = SRC_IDLE;
      rx_sel_o[c] = SRC_IDLE;
    end
    if (ctrl_i.active) begin
      // line loopback wins over per-channel loopbacks
      tx_sel_o[0] = (ctrl_i.line_lb || ctrl_i.b1_lb) ? SRC_LINE : SRC_SYS;
      tx_sel_o[1] = (ctrl_i.line_lb || ctrl_i.b2_lb) ? SRC_LINE : SRC_SYS;
      tx_sel_o[2] = ctrl_i.line_lb ? SRC_LINE :
                    (ctrl_i.dtx_dis ? SRC_IDLE : SRC_SYS);
      rx_sel_o[0] = ctrl_i.dig_lb ? SRC_SYS : SRC_LINE;
      rx_sel_o[1] = ctrl_i.dig_lb ? SRC_SYS : SRC_LINE;
      rx_sel_o[2] = ctrl_i.drx_dis ? SRC_IDLE :
                    (ctrl_i.dig_lb ? SRC_SYS : SRC_LINE);
    end
  end
endmodule

// File: rtl/lcr_chan_reg.sv
module lcr_chan_reg
  import lcr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  src_e         sel_i,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] sys_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (sel_i)
      SRC_SYS:  nxt = sys_i;
      SRC_LINE: nxt = line_i;
      default:  nxt = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '1;
    else if (frame_i) q_o <= nxt;
  end
endmodule

// File: rtl/line_ctrl_router.sv
module line_ctrl_router
  import lcr_pkg::*;
#(
  parameter int unsigned B_W = 8,
  parameter int unsigned D_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_en_o,
  input  logic              frame_i,
  input  logic [B_W-1:0]    line_rx_b1_i,
  input  logic [B_W-1:0]    line_rx_b2_i,
  input  logic [D_W-1:0]    line_rx_d_i,
  input  logic [B_W-1:0]    sys_tx_b1_i,
  input  logic [B_W-1:0]    sys_tx_b2_i,
  input  logic [D_W-1:0]    sys_tx_d_i,
  output logic [B_W-1:0]    line_tx_b1_o,
  output logic [B_W-1:0]    line_tx_b2_o,
  output logic [D_W-1:0]    line_tx_d_o,
  output logic [B_W-1:0]    sys_rx_b1_o,
  output logic [B_W-1:0]    sys_rx_b2_o,
  output logic [D_W-1:0]    sys_rx_d_o
);
  localparam int unsigned CH_W = 2 * B_W + D_W;

  ctrl_t ctrl_q;
  src_e  tx_sel [NUM_CH];
  src_e  rx_sel [NUM_CH];

  logic [CH_W-1:0] line_in, sys_in, line_out, sys_out;

  assign line_in = {line_rx_b1_i, line_rx_b2_i, line_rx_d_i};
  assign sys_in  = {sys_tx_b1_i,  sys_tx_b2_i,  sys_tx_d_i};

  lcr_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_q)
  );

  lcr_sel_decode u_dec (
    .ctrl_i   (ctrl_q),
    .tx_sel_o (tx_sel),
    .rx_sel_o (rx_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned W  = (c == 2) ? D_W : B_W;
    localparam int unsigned LO = (c == 0) ? (B_W + D_W) : ((c == 1) ? D_W : 0);

    lcr_chan_reg #(.W(W)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i),
      .sel_i   (tx_sel[c]),
      .line_i  (line_in[LO +: W]),
      .sys_i   (sys_in[LO +: W]),
      .q_o     (line_out[LO +: W])
    );

    lcr_chan_reg #(.W(W)) u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i),
      .sel_i   (rx_sel[c]),
      .line_i  (line_in[LO +: W]),
      .sys_i   (sys_in[LO +: W]),
      .q_o     (sys_out[LO +: W])
    );
  end

  assign {line_tx_b1_o, line_tx_b2_o, line_tx_d_o} = line_out;
  assign {sys_rx_b1_o,  sys_rx_b2_o,  sys_rx_d_o}  = sys_out;
  assign ctrl_o   = ctrl_q;
  assign irq_en_o = ctrl_q.irq_en;
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
  parameter int unsigned B_W = 8,
  parameter int unsigned D_W = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [7:0]     wr_data_i,
  input logic [7:0]     ctrl_o,
  input logic           irq_en_o,
  input logic           frame_i,
  input logic [B_W-1:0] line_rx_b1_i,
  input logic [B_W-1:0] line_rx_b2_i,
  input logic [D_W-1:0] line_rx_d_i,
  input logic [B_W-1:0] sys_tx_b1_i,
  input logic [B_W-1:0] sys_tx_b2_i,
  input logic [D_W-1:0] sys_tx_d_i,
  input logic [B_W-1:0] line_tx_b1_o,
  input logic [B_W-1:0] line_tx_b2_o,
  input logic [D_W-1:0] line_tx_d_o,
  input logic [B_W-1:0] sys_rx_b1_o,
  input logic [B_W-1:0] sys_rx_b2_o,
  input logic [D_W-1:0] sys_rx_d_o
);
  AST_WRITE_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_o == $past(wr_data_i)); // R2

  AST_INACTIVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !ctrl_o[7]) |=> (&line_tx_b1_o) && (&line_tx_b2_o) && (&line_tx_d_o)
                                && (&sys_rx_b1_o) && (&sys_rx_b2_o) && (&sys_rx_d_o)); // R3

  AST_LINE_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && ctrl_o[7] && ctrl_o[5]) |=> line_tx_b1_o == $past(line_rx_b1_i)
      && line_tx_b2_o == $past(line_rx_b2_i) && line_tx_d_o == $past(line_rx_d_i)); // R5

  AST_DIG_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && ctrl_o[7] && ctrl_o[6]) |=> sys_rx_b1_o == $past(sys_tx_b1_i)
      && sys_rx_b2_o == $past(sys_tx_b2_i)); // R9

  AST_DTX_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && ctrl_o[7] && ctrl_o[1] && !ctrl_o[5]) |=> &line_tx_d_o); // R11

  AST_DRX_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && ctrl_o[7] && ctrl_o[0]) |=> &sys_rx_d_o); // R12

  AST_HOLD_OFF_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(line_tx_b1_o) && $stable(line_tx_b2_o) && $stable(line_tx_d_o)
      && $stable(sys_rx_b1_o) && $stable(sys_rx_b2_o) && $stable(sys_rx_d_o)); // R13
endmodule

bind line_ctrl_router lcr_checker #(.B_W(B_W), .D_W(D_W)) u_chk (.*);

// File: tb/line_ctrl_router_tb.sv
module line_ctrl_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int B_W = 8;
  localparam int D_W = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic frame = 1'b0;
  logic [B_W-1:0] lrx_b1 = '0, lrx_b2 = '0, stx_b1 = '0, stx_b2 = '0;
  logic [D_W-1:0] lrx_d = '0, stx_d = '0;
  logic [7:0] ctrl;
  logic irq_en;
  logic [B_W-1:0] ltx_b1, ltx_b2, srx_b1, srx_b2;
  logic [D_W-1:0] ltx_d, srx_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_ctrl_router #(.B_W(B_W), .D_W(D_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .irq_en_o(irq_en), .frame_i(frame),
    .line_rx_b1_i(lrx_b1), .line_rx_b2_i(lrx_b2), .line_rx_d_i(lrx_d),
    .sys_tx_b1_i(stx_b1), .sys_tx_b2_i(stx_b2), .sys_tx_d_i(stx_d),
    .line_tx_b1_o(ltx_b1), .line_tx_b2_o(ltx_b2), .line_tx_d_o(ltx_d),
    .sys_rx_b1_o(srx_b1), .sys_rx_b2_o(srx_b2), .sys_rx_d_o(srx_d)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  string tag = "R1";

  // behavioural reference model
  int m_ctrl;
  int e_lb1, e_lb2, e_ld, e_sb1, e_sb2, e_sd;

  function automatic bit bitof(int v, int b);
    return ((v >> b) & 1) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      e_lb1 = 255; e_lb2 = 255; e_ld = 3; e_sb1 = 255; e_sb2 = 255; e_sd = 3;
    end else begin
      if (frame) begin
        if (!bitof(m_ctrl, 7)) begin
          e_lb1 = 255; e_lb2 = 255; e_ld = 3; e_sb1 = 255; e_sb2 = 255; e_sd = 3;
        end else begin
          e_lb1 = int'(stx_b1); e_lb2 = int'(stx_b2);
          e_ld  = bitof(m_ctrl, 1) ? 3 : int'(stx_d);
          if (bitof(m_ctrl, 4)) e_lb1 = int'(lrx_b1);
          if (bitof(m_ctrl, 3)) e_lb2 = int'(lrx_b2);
          if (bitof(m_ctrl, 5)) begin
            e_lb1 = int'(lrx_b1); e_lb2 = int'(lrx_b2); e_ld = int'(lrx_d);
          end
          if (bitof(m_ctrl, 6)) begin
            e_sb1 = int'(stx_b1); e_sb2 = int'(stx_b2); e_sd = int'(stx_d);
          end else begin
            e_sb1 = int'(lrx_b1); e_sb2 = int'(lrx_b2); e_sd = int'(lrx_d);
          end
          if (bitof(m_ctrl, 0)) e_sd = 3;
        end
      end
      if (wr_en) m_ctrl = int'(wr_data);
    end
  end

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("ctrl_o (R2)", int'(ctrl), m_ctrl);
    chk("irq_en_o (R10)", int'(irq_en), bitof(m_ctrl, 2) ? 1 : 0);
    chk("line_tx_b1", int'(ltx_b1), e_lb1);
    chk("line_tx_b2", int'(ltx_b2), e_lb2);
    chk("line_tx_d",  int'(ltx_d),  e_ld);
    chk("sys_rx_b1",  int'(srx_b1), e_sb1);
    chk("sys_rx_b2",  int'(srx_b2), e_sb2);
    chk("sys_rx_d",   int'(srx_d),  e_sd);
  endtask

  // one negedge: compare, then drive fresh inputs; frame every third cycle (R13)
  task automatic step(bit do_wr, logic [7:0] val);
    @(negedge clk);
    cycles++;
    compare_all();
    wr_en   = do_wr;
    wr_data = val;
    frame   = (cycles % 3) == 0;
    lrx_b1 = 8'($urandom); lrx_b2 = 8'($urandom); lrx_d = 2'($urandom);
    stx_b1 = 8'($urandom); stx_b2 = 8'($urandom); stx_d = 2'($urandom);
  endtask

  task automatic phase(string t, logic [7:0] val);
    tag = t;
    step(1'b1, val);
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00);
  endtask

  initial begin
    int wd = 0;
    while (wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    $display("FAIL watchdog expired: actual %0d expected <%0d cycles", wd, WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00);
    phase("R2_R3_inactive_loops", 8'h7F);
    phase("R4_plain", 8'h80);
    phase("R5_line_loop", 8'hA0);
    phase("R6_b1_loop", 8'h90);
    phase("R7_b2_loop", 8'h88);
    phase("R8_priority", 8'hB8);
    phase("R9_digital", 8'hC0);
    phase("R10_irq", 8'h84);
    phase("R11_dtx_off", 8'h82);
    phase("R11_dtx_off_with_line_loop", 8'hA2);
    phase("R12_drx_off", 8'hC1);
    phase("R3_deactivate", 8'h3F);
    tag = "R13_write_on_frame";
    for (int i = 0; i < 30; i++) step(1'b1, 8'($urandom) | 8'h80);
    phase("R13_settle", 8'hE5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule